// File: doc/BRIEF.md
# Latched 64-to-32-bit IO bridge

This block connects the IO leg of a 64-bit processor bus to a group of 32-bit IO device slaves. The address decode ahead of it has already split the processor's accesses among block RAM, DRAM and IO, and only IO accesses reach this block. It first captures the whole request in registers, so the slave side is driven only from flops and the long main-bus path ends here.

From the captured byte enables it works out whether the low word, the high word or both are touched. It then runs one or two 32-bit accesses, low word first, each sent to the single device whose address window matches. Each returned word is placed in its own lane of the 64-bit read data, and the master is acknowledged once, after the last access.

An address that falls in no device window is still completed, with all-ones data, so a stray access cannot hang the bus. Only one request is in flight at a time. The master holds its cycle and strobe until it sees the acknowledge, and the stall output shows that the bridge is busy.

Top module: `io_bridge_w64to32`

## Requirements
- R1: The request is captured in registers when m_cyc and m_stb are high while the bridge is idle. s_stb and s_cyc stay low in the cycle where the request first appears, and rise only after the capturing clock edge.
- R2: If m_sel[7:4] is zero, exactly one 32-bit access is made. It has s_adr = {m_adr, 1'b0}, s_sel = m_sel[3:0] and s_dat_w = m_dat_w[31:0]. A request with m_sel all zero also takes this path.
- R3: If m_sel[3:0] is zero and m_sel[7:4] is not zero, exactly one access is made. It has s_adr = {m_adr, 1'b1}, s_sel = m_sel[7:4] and s_dat_w = m_dat_w[63:32].
- R4: If both halves of m_sel are non-zero, two accesses are made: the low word (s_adr bit 2 = 0) first, then the high word. m_ack follows the second completion only.
- R5: Read data from the low word appears in m_dat_r[31:0] and read data from the high word in m_dat_r[63:32]. A lane that was not accessed reads as zero.
- R6: The device index is s_adr[AW-1:DEV_SHIFT]. When this index is below N_DEV, only s_cyc[index] is raised during the access, and s_cyc is never more than one-hot.
- R7: An access whose index is N_DEV or above raises no s_cyc bit and no s_stb. It completes in one cycle, with all-ones data in its lane, and the master is still acknowledged.
- R8: m_stall is high from the cycle after capture through the acknowledge cycle. m_ack is a single-cycle pulse, and in the cycle after it, m_stall is low.
- R9: While reset is applied, m_ack, m_stall, s_cyc and s_stb are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_cyc | input | 1 | Master cycle, held until m_ack |
| m_stb | input | 1 | Master strobe, held until m_ack |
| m_we | input | 1 | Master write enable |
| m_adr | input | AW-3 | Master doubleword address (byte address bits AW-1..3) |
| m_sel | input | 8 | Master byte enables |
| m_dat_w | input | 64 | Master write data |
| m_dat_r | output | 64 | Read data returned to master |
| m_ack | output | 1 | Single-cycle completion pulse |
| m_stall | output | 1 | Bridge busy with a request |
| s_cyc | output | N_DEV | One-hot cycle for each device |
| s_stb | output | 1 | Shared strobe for devices |
| s_we | output | 1 | Shared write enable |
| s_adr | output | AW-2 | Word address (byte address bits AW-1..2) |
| s_sel | output | 4 | Byte enables for the current word |
| s_dat_w | output | 32 | Write data for the current word |
| s_dat_r | input | N_DEV*32 | Read data, 32 bits per device |
| s_ack | input | N_DEV | Acknowledge per device |

## Verification
The hardest case to reach is a split access. Here the two words are handled back to back by a device with several cycles of latency. The acknowledge must wait for the second word, and the lanes must not swap or leak into each other. The stimulus sweeps every address window, mapped and unmapped, and pairs each window with byte-enable patterns for low only, high only, both halves and single bytes. The bench slaves give each device a different ack latency. Every write is then read back with the same enables and compared against a bench-side memory image, and the address, enables and data of each slave handshake are checked too.

// File: rtl/iob_pkg.sv
package iob_pkg;
    localparam int M_DW   = 64;
    localparam int S_DW   = 32;
    localparam int M_SELW = M_DW / 8;
    localparam int S_SELW = S_DW / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } iob_state_e;
endpackage

// File: rtl/iob_half_plan.sv
module iob_half_plan
    import iob_pkg::*;
(
    input  logic [M_SELW-1:0] sel,
    output logic              start_hi,
    output logic              both
);
    logic lo_any;
    logic hi_any;

    always_comb begin
        lo_any   = |sel[S_SELW-1:0];
        hi_any   = |sel[M_SELW-1:S_SELW];
        start_hi = hi_any && !lo_any;
        both     = hi_any && lo_any;
    end
endmodule

// File: rtl/iob_dev_decode.sv
module iob_dev_decode #(
    parameter int WIN_W = 4,
    parameter int N_DEV = 4
) (
    input  logic [WIN_W-1:0] win,
    output logic [N_DEV-1:0] dev_oh,
    output logic             hit
);
    for (genvar i = 0; i < N_DEV; i++) begin : g_win
        assign dev_oh[i] = (win == WIN_W'(i));
    end

    assign hit = |dev_oh;
endmodule

// File: rtl/iob_rdata_mux.sv
module iob_rdata_mux
    import iob_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic [N_DEV*S_DW-1:0] dat_in,
    input  logic [N_DEV-1:0]      ack_in,
    input  logic [N_DEV-1:0]      gate,
    output logic [S_DW-1:0]       dat_out,
    output logic                  ack_out
);
    always_comb begin
        dat_out = '0;
        ack_out = 1'b0;
        for (int i = 0; i < N_DEV; i++) begin
            if (gate[i]) begin
                dat_out = dat_out | dat_in[i*S_DW +: S_DW];
                ack_out = ack_out | ack_in[i];
            end
        end
    end
endmodule

// File: rtl/io_bridge_w64to32.sv
module io_bridge_w64to32
    import iob_pkg::*;
#(
    parameter int AW        = 16,
    parameter int N_DEV     = 4,
    parameter int DEV_SHIFT = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  m_cyc,
    input  logic                  m_stb,
    input  logic                  m_we,
    input  logic [AW-1:3]         m_adr,
    input  logic [M_SELW-1:0]     m_sel,
    input  logic [M_DW-1:0]       m_dat_w,
    output logic [M_DW-1:0]       m_dat_r,
    output logic                  m_ack,
    output logic                  m_stall,
    output logic [N_DEV-1:0]      s_cyc,
    output logic                  s_stb,
    output logic                  s_we,
    output logic [AW-1:2]         s_adr,
    output logic [S_SELW-1:0]     s_sel,
    output logic [S_DW-1:0]       s_dat_w,
    input  logic [N_DEV*S_DW-1:0] s_dat_r,
    input  logic [N_DEV-1:0]      s_ack
);
    localparam int WIN_W = AW - DEV_SHIFT;

    typedef struct packed {
        iob_state_e          state;
        logic                half;
        logic                more;
        logic                we;
        logic [AW-1:3]       adr;
        logic [M_SELW-1:0]   sel;
        logic [M_DW-1:0]     wdat;
        logic [M_DW-1:0]     rdat;
    } regs_t;

    regs_t q, d;

    logic             plan_start_hi;
    logic             plan_both;
    logic [N_DEV-1:0] dev_oh;
    logic             dev_hit;
    logic [N_DEV-1:0] cyc_gate;
    logic [S_DW-1:0]  word_rd;
    logic             word_ack;
    logic [S_DW-1:0]  lane_val;
    logic             word_done;

    iob_half_plan u_plan (
        .sel      (m_sel),
        .start_hi (plan_start_hi),
        .both     (plan_both)
    );

    iob_dev_decode #(.WIN_W(WIN_W), .N_DEV(N_DEV)) u_dec (
        .win    (q.adr[AW-1:DEV_SHIFT]),
        .dev_oh (dev_oh),
        .hit    (dev_hit)
    );

    assign cyc_gate = (q.state == ST_XFER) ? dev_oh : '0;

    iob_rdata_mux #(.N_DEV(N_DEV)) u_rmux (
        .dat_in  (s_dat_r),
        .ack_in  (s_ack),
        .gate    (cyc_gate),
        .dat_out (word_rd),
        .ack_out (word_ack)
    );

    // slave side driven from registered state only
    always_comb begin
        s_cyc   = cyc_gate;
        s_stb   = (q.state == ST_XFER) && dev_hit;
        s_we    = q.we;
        s_adr   = {q.adr, q.half};
        s_sel   = q.half ? q.sel[M_SELW-1:S_SELW] : q.sel[S_SELW-1:0];
        s_dat_w = q.half ? q.wdat[M_DW-1:S_DW] : q.wdat[S_DW-1:0];
        m_ack   = (q.state == ST_DONE);
        m_stall = (q.state != ST_IDLE);
        m_dat_r = q.rdat;
    end

    always_comb begin
        d         = q;
        lane_val  = dev_hit ? word_rd : '1;
        word_done = !dev_hit || word_ack;
        case (q.state)
            ST_IDLE: begin
                if (m_cyc && m_stb) begin
                    d.state = ST_XFER;
                    d.we    = m_we;
                    d.adr   = m_adr;
                    d.sel   = m_sel;
                    d.wdat  = m_dat_w;
                    d.rdat  = '0;
                    d.half  = plan_start_hi;
                    d.more  = plan_both;
                end
            end
            ST_XFER: begin
                if (word_done) begin
                    if (q.half) begin
                        d.rdat[M_DW-1:S_DW] = lane_val;
                    end else begin
                        d.rdat[S_DW-1:0] = lane_val;
                    end
                    if (q.more) begin
                        d.more = 1'b0;
                        d.half = 1'b1;
                    end else begin
                        d.state = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/iob_bridge_chk.sv
module iob_bridge_chk #(
    parameter int N_DEV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             m_cyc,
    input logic             m_stb,
    input logic             m_ack,
    input logic             m_stall,
    input logic [N_DEV-1:0] s_cyc,
    input logic             s_stb
);
    p_cyc_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_cyc));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !m_stall |-> (s_cyc == '0 && !s_stb));

    p_stb_after_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_stb) |-> $past(m_cyc && m_stb));

    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |=> !m_ack);

    p_ack_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |=> !m_stall);

    p_stall_ends_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_stall) |-> $past(m_ack));
endmodule

bind io_bridge_w64to32 iob_bridge_chk #(.N_DEV(N_DEV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_cyc   (m_cyc),
    .m_stb   (m_stb),
    .m_ack   (m_ack),
    .m_stall (m_stall),
    .s_cyc   (s_cyc),
    .s_stb   (s_stb)
);

// File: tb/io_bridge_w64to32_tb_top.sv
module io_bridge_w64to32_tb_top;
    localparam int AW        = 16;
    localparam int N_DEV     = 4;
    localparam int DEV_SHIFT = 12;
    localparam int N_WIN     = 1 << (AW - DEV_SHIFT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                  m_cyc = 0, m_stb = 0, m_we = 0;
    logic [AW-1:3]         m_adr = '0;
    logic [7:0]            m_sel = '0;
    logic [63:0]           m_dat_w = '0;
    logic [63:0]           m_dat_r;
    logic                  m_ack, m_stall;
    logic [N_DEV-1:0]      s_cyc;
    logic                  s_stb, s_we;
    logic [AW-1:2]         s_adr;
    logic [3:0]            s_sel;
    logic [31:0]           s_dat_w;
    logic [N_DEV*32-1:0]   s_dat_r;
    logic [N_DEV-1:0]      s_ack;

    io_bridge_w64to32 #(.AW(AW), .N_DEV(N_DEV), .DEV_SHIFT(DEV_SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr),
        .m_sel(m_sel), .m_dat_w(m_dat_w), .m_dat_r(m_dat_r),
        .m_ack(m_ack), .m_stall(m_stall),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
        .s_sel(s_sel), .s_dat_w(s_dat_w), .s_dat_r(s_dat_r), .s_ack(s_ack)
    );

    // device models: device d acks d cycles after its strobe arrives
    logic [31:0] sl_mem [N_DEV][16];
    logic [31:0] sl_rd  [N_DEV];
    int          sl_cnt [N_DEV];

    always @(posedge clk) begin
        for (int dv = 0; dv < N_DEV; dv++) begin
            if (!rst_n) begin
                s_ack[dv]  <= 1'b0;
                sl_cnt[dv] <= 0;
                sl_rd[dv]  <= '0;
                for (int w = 0; w < 16; w++) sl_mem[dv][w] <= '0;
            end else if (s_cyc[dv] && s_stb && !s_ack[dv]) begin
                if (sl_cnt[dv] == dv) begin
                    s_ack[dv]  <= 1'b1;
                    sl_cnt[dv] <= 0;
                    sl_rd[dv]  <= sl_mem[dv][s_adr[5:2]];
                    if (s_we) begin
                        for (int b = 0; b < 4; b++)
                            if (s_sel[b]) sl_mem[dv][s_adr[5:2]][b*8 +: 8] <= s_dat_w[b*8 +: 8];
                    end
                end else begin
                    sl_cnt[dv] <= sl_cnt[dv] + 1;
                end
            end else begin
                s_ack[dv] <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int dv = 0; dv < N_DEV; dv++) s_dat_r[dv*32 +: 32] = sl_rd[dv];
    end

    // handshake monitor
    int               hs_n = 0;
    logic [AW-1:2]    hs_adr [4];
    logic [3:0]       hs_sel [4];
    logic [31:0]      hs_dat [4];
    logic [N_DEV-1:0] hs_dev [4];

    always @(posedge clk) begin
        if (rst_n && s_stb && |(s_cyc & s_ack)) begin
            hs_adr[hs_n % 4] <= s_adr;
            hs_sel[hs_n % 4] <= s_sel;
            hs_dat[hs_n % 4] <= s_dat_w;
            hs_dev[hs_n % 4] <= s_cyc;
            hs_n <= hs_n + 1;
        end
    end

    int checks = 0;
    int failures = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_xfer(input logic [AW-1:3] adr, input logic we, input logic [7:0] sel,
                           input logic [63:0] wd, output logic [63:0] rd,
                           output int hs_seen, output int base, output bit stall_ok,
                           output bit timed_out);
        int n;
        @(negedge clk);
        base = hs_n;
        m_cyc = 1; m_stb = 1; m_we = we; m_adr = adr; m_sel = sel; m_dat_w = wd;
        #1;
        check("R1", {62'b0, s_stb, |s_cyc}, 64'd0);
        stall_ok = 1; timed_out = 0; n = 0;
        forever begin
            @(negedge clk);
            if (m_ack) break;
            if (!m_stall) stall_ok = 0;
            n++;
            if (n > 100) begin
                timed_out = 1;
                break;
            end
        end
        rd = m_dat_r;
        hs_seen = hs_n - base;
        if (!m_stall) stall_ok = 0;
        m_cyc = 0; m_stb = 0;
        @(negedge clk);
        if (m_ack || m_stall) stall_ok = 0;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    logic [31:0] exp_mem [N_DEV][16];
    logic [7:0]  sel_list [7];

    initial begin
        for (int dv = 0; dv < N_DEV; dv++)
            for (int w = 0; w < 16; w++) exp_mem[dv][w] = '0;
        sel_list[0] = 8'h0F; sel_list[1] = 8'hF0; sel_list[2] = 8'hFF;
        sel_list[3] = 8'h01; sel_list[4] = 8'h80; sel_list[5] = 8'h3C;
        sel_list[6] = 8'hC3;

        repeat (3) @(negedge clk);
        check("R9", {60'b0, m_ack, m_stall, s_stb, |s_cyc}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R9", {60'b0, m_ack, m_stall, s_stb, |s_cyc}, 64'd0);

        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < N_WIN; w++) begin
                for (int si = 0; si < 7; si++) begin
                    logic [AW-1:3] dw;
                    logic [7:0]    sel;
                    logic [63:0]   wd, rd, exp_rd;
                    logic          lo, hi, mapped, fh;
                    int            hs, base, exp_hs, wi;
                    bit            st_ok, to;
                    string         rq;

                    dw     = {4'(w), 9'(si)};
                    sel    = sel_list[si];
                    wd     = {16'(w * 257 + si), 16'(16'hC0DE + p), 16'(si * 13 + p), 16'(w * 3 + 1)};
                    lo     = (|sel[3:0]) || (sel == 8'h00);
                    hi     = |sel[7:4];
                    mapped = (w < N_DEV);
                    fh     = !lo;
                    exp_hs = mapped ? (int'(lo) + int'(hi)) : 0;
                    wi     = {dw[5:3], 1'b0};
                    rq     = (lo && hi) ? "R4" : (lo ? "R2" : "R3");

                    // write
                    do_xfer(dw, 1'b1, sel, wd, rd, hs, base, st_ok, to);
                    check(mapped ? rq : "R7", 64'(to), 64'd0);
                    check(mapped ? rq : "R7", 64'(hs), 64'(exp_hs));
                    check("R8", 64'(st_ok), 64'd1);
                    if (mapped && hs == exp_hs) begin
                        check(rq, 64'(hs_adr[base % 4]), 64'({dw, fh}));
                        check(rq, 64'(hs_sel[base % 4]), fh ? 64'(sel[7:4]) : 64'(sel[3:0]));
                        check(rq, 64'(hs_dat[base % 4]), fh ? 64'(wd[63:32]) : 64'(wd[31:0]));
                        check("R6", 64'(hs_dev[base % 4]), 64'(1 << w));
                        if (lo && hi) begin
                            check("R4", 64'(hs_adr[(base + 1) % 4]), 64'({dw, 1'b1}));
                            check("R4", 64'(hs_sel[(base + 1) % 4]), 64'(sel[7:4]));
                            check("R4", 64'(hs_dat[(base + 1) % 4]), 64'(wd[63:32]));
                        end
                    end
                    if (mapped) begin
                        if (lo) exp_mem[w][wi]     = merge(exp_mem[w][wi], wd[31:0], sel[3:0]);
                        if (hi) exp_mem[w][wi + 1] = merge(exp_mem[w][wi + 1], wd[63:32], sel[7:4]);
                    end

                    // read back with the same enables
                    do_xfer(dw, 1'b0, sel, 64'd0, rd, hs, base, st_ok, to);
                    exp_rd = '0;
                    if (lo) exp_rd[31:0]  = mapped ? exp_mem[w][wi]     : 32'hFFFF_FFFF;
                    if (hi) exp_rd[63:32] = mapped ? exp_mem[w][wi + 1] : 32'hFFFF_FFFF;
                    check(mapped ? "R5" : "R7", rd, exp_rd);
                    check("R8", 64'(st_ok), 64'd1);
                    check(mapped ? rq : "R7", 64'(hs), 64'(exp_hs));
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule